// File: doc/BRIEF.md
# Power-Control Register Access Engine

This block sits on the service-processor side of a mailbox. It executes one register-access request at a time against a byte-wide power-control register space. A request arrives as a one-cycle start pulse. The pulse carries a message type, a sub-command id, a size field and a 20-byte request buffer, and the engine captures all of them on the cycle it accepts the start.

The engine decodes the request into one of three operations:
- a read of up to five registers;
- a write of up to five registers;
- a single-register masked read-modify-write.

It then walks the packed little-endian address list and drives a synchronous register port, one access per cycle.

Read results are collected into a 16-byte result buffer. Completion is reported by a one-cycle done pulse. A malformed request produces the same done pulse with an error flag and makes no register access at all.

Top module: `pcr_access_engine`

## Requirements
- R1: After reset, busy, done, error and write enable are low and every result-buffer bit is zero.
- R2: With message type 0xFF, sub-command id 1 and size 2×N (N from 1 to 5), the engine reads N registers. Register i takes its address from request bytes 2i (low byte) and 2i+1 (high byte). The byte read from register i is placed in result byte i.
- R3: With message type 0xFF, sub-command id 0 and size 3×N (N from 1 to 5), the engine writes N registers in list order. Register i receives request byte 2N+i, and exactly N write-enable cycles occur.
- R4: With message type 0xFF, sub-command id 2 and size 4, the engine reads the register addressed by bytes 0–1 and then writes the same address once. The written value takes each bit from byte 2 where byte 3 has a 1, and keeps the old register bit where byte 3 has a 0.
- R5: Any of the following ends the request with done and error high and no write enable: a message type other than 0xFF, a sub-command id above 2, a size of zero, a size that is not an exact multiple for the operation, or a size other than 4 for read-modify-write.
- R6: Busy rises on the cycle after an accepted start and stays high through the cycle of the done pulse. A start pulse seen while busy is high is ignored and causes no access and no extra done.
- R7: Done is high for exactly one cycle per accepted request. Error is high only together with done, and is low on a successful request.
- R8: The result buffer is cleared when a request is accepted, so bytes at positions N and above read zero after an N-item read.
- R9: Five items is the largest accepted count: a read of size 10 or a write of size 15 completes without error, while a size implying six items is rejected as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| msg_type_i | input | 8 | Message type; 0xFF selects power-control access |
| sub_id_i | input | 4 | Sub-command id: 0 write, 1 read, 2 read-modify-write |
| size_i | input | 8 | Encoded payload size |
| req_buf_i | input | 160 | Request bytes, byte k at bits 8k+7:8k |
| reg_addr_o | output | 16 | Register port address |
| reg_wdata_o | output | 8 | Register port write data |
| reg_we_o | output | 1 | Register port write enable |
| reg_rdata_i | input | 8 | Register port read data, valid one cycle after the address |
| rsp_buf_o | output | 128 | Result bytes, byte k at bits 8k+7:8k |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected, valid with done |

## Verification
The embedded properties assume two things about the surroundings. First, the register space answers a read on the clock edge that follows the address, which is why the read-modify-write address must hold from its read cycle into its write cycle. Second, start is a single-cycle strobe whose companion fields only matter on the accept cycle. The bench keeps within both. Its register model registers read data on every rising edge from the presented address, and it drives every input at the falling edge and drops start after one cycle. The only deliberate violation is the repeated start during busy, whose contents must leave no trace in the register model.

// File: rtl/pcr_pkg.sv
package pcr_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int MSG_W  = 8;
    localparam int SUB_W  = 4;
    localparam int SIZE_W = 8;

    localparam logic [MSG_W-1:0] MSG_PWR_CTRL = 8'hFF;
    localparam logic [SUB_W-1:0] SUB_WRITE    = 4'd0;
    localparam logic [SUB_W-1:0] SUB_READ     = 4'd1;
    localparam logic [SUB_W-1:0] SUB_RMW      = 4'd2;

    // payload multipliers per item and fixed masked-update layout
    localparam int RD_BYTES_PER_ITEM = 2;
    localparam int WR_BYTES_PER_ITEM = 3;
    localparam int RMW_SIZE          = 4;
    localparam int RMW_VAL_POS       = 2;
    localparam int RMW_MASK_POS      = 3;

    typedef enum logic [1:0] {
        OP_WR  = 2'd0,
        OP_RD  = 2'd1,
        OP_RMW = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_CAPT  = 2'd2,
        ST_MOD   = 2'd3
    } st_e;

    function automatic logic [DATA_W-1:0] merge_bits(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [DATA_W-1:0] sel
    );
        return (old_v & ~sel) | (new_v & sel);
    endfunction

endpackage

// File: rtl/pcr_req_decode.sv
module pcr_req_decode
    import pcr_pkg::*;
#(
    parameter int MAX_ITEMS = 5,
    parameter int IDX_W     = 3
) (
    input  logic [MSG_W-1:0]  msg_i,
    input  logic [SUB_W-1:0]  sub_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              ok_o,
    output op_e               op_o,
    output logic [IDX_W-1:0]  count_o
);

    logic [MAX_ITEMS:1] rd_hit;
    logic [MAX_ITEMS:1] wr_hit;

    for (genvar k = 1; k <= MAX_ITEMS; k++) begin : g_hit
        assign rd_hit[k] = (size_i == SIZE_W'(RD_BYTES_PER_ITEM * k));
        assign wr_hit[k] = (size_i == SIZE_W'(WR_BYTES_PER_ITEM * k));
    end

    always_comb begin
        ok_o    = 1'b0;
        op_o    = OP_WR;
        count_o = '0;
        if (msg_i == MSG_PWR_CTRL) begin
            case (sub_i)
                SUB_WRITE: begin
                    op_o = OP_WR;
                    for (int k = 1; k <= MAX_ITEMS; k++) begin
                        if (wr_hit[k]) begin
                            count_o = IDX_W'(k);
                            ok_o    = 1'b1;
                        end
                    end
                end
                SUB_READ: begin
                    op_o = OP_RD;
                    for (int k = 1; k <= MAX_ITEMS; k++) begin
                        if (rd_hit[k]) begin
                            count_o = IDX_W'(k);
                            ok_o    = 1'b1;
                        end
                    end
                end
                SUB_RMW: begin
                    op_o = OP_RMW;
                    if (size_i == SIZE_W'(RMW_SIZE)) begin
                        count_o = IDX_W'(1);
                        ok_o    = 1'b1;
                    end
                end
                default: ok_o = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (ok_o) begin
            AST_CNT_RANGE: assert (count_o != '0 && int'(count_o) <= MAX_ITEMS); // R9
        end
    end

endmodule

// File: rtl/pcr_rsp_store.sv
module pcr_rsp_store
    import pcr_pkg::*;
#(
    parameter int RSP_BYTES = 16,
    parameter int IDX_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr_i,
    input  logic                      wr_i,
    input  logic [IDX_W-1:0]          idx_i,
    input  logic [DATA_W-1:0]         data_i,
    output logic [RSP_BYTES*8-1:0]    rsp_o
);

    localparam int PW = $clog2(RSP_BYTES * 8);

    logic [RSP_BYTES*8-1:0] rsp_q;
    logic [PW-1:0]          pos;

    assign pos   = PW'({idx_i, 3'b000});
    assign rsp_o = rsp_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            rsp_q <= '0;
        end else if (wr_i) begin
            rsp_q[pos +: DATA_W] <= data_i;
        end
    end

    AST_CAP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_i |-> (int'(idx_i) < RSP_BYTES && !clr_i)); // R2

endmodule

// File: rtl/pcr_seq.sv
module pcr_seq
    import pcr_pkg::*;
#(
    parameter int MAX_ITEMS = 5,
    parameter int REQ_BYTES = 20,
    parameter int IDX_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic                    ok_i,
    input  op_e                     op_i,
    input  logic [IDX_W-1:0]        count_i,
    input  logic [REQ_BYTES*8-1:0]  req_buf_i,
    output logic [ADDR_W-1:0]       reg_addr_o,
    output logic [DATA_W-1:0]       reg_wdata_o,
    output logic                    reg_we_o,
    input  logic [DATA_W-1:0]       reg_rdata_i,
    output logic                    clr_o,
    output logic                    cap_en_o,
    output logic [IDX_W-1:0]        cap_idx_o,
    output logic [DATA_W-1:0]       cap_data_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    err_o
);

    localparam int BIX_W = $clog2(REQ_BYTES);
    localparam int PW    = $clog2(REQ_BYTES * 8);

    st_e                    st_q;
    op_e                    op_q;
    logic [IDX_W-1:0]       cnt_q;
    logic [IDX_W-1:0]       idx_q;
    logic [REQ_BYTES*8-1:0] req_q;
    logic [DATA_W-1:0]      old_q;
    logic                   done_q;
    logic                   err_q;

    logic                   accept;
    logic                   last;
    logic [BIX_W-1:0]       lo_ix;
    logic [BIX_W-1:0]       hi_ix;
    logic [BIX_W-1:0]       wd_ix;

    function automatic logic [DATA_W-1:0] req_byte(input logic [BIX_W-1:0] ix);
        return req_q[PW'({ix, 3'b000}) +: DATA_W];
    endfunction

    assign accept = start_i && (st_q == ST_IDLE) && !done_q;
    assign last   = (idx_q == cnt_q - IDX_W'(1));
    assign lo_ix  = BIX_W'({idx_q, 1'b0});
    assign hi_ix  = lo_ix + BIX_W'(1);
    assign wd_ix  = BIX_W'({cnt_q, 1'b0}) + BIX_W'(idx_q);

    assign reg_addr_o  = {req_byte(hi_ix), req_byte(lo_ix)};
    assign reg_we_o    = ((st_q == ST_ISSUE) && (op_q == OP_WR)) || (st_q == ST_MOD);
    assign reg_wdata_o = (st_q == ST_MOD)
                       ? merge_bits(old_q, req_byte(BIX_W'(RMW_VAL_POS)), req_byte(BIX_W'(RMW_MASK_POS)))
                       : req_byte(wd_ix);

    assign clr_o      = accept;
    assign cap_en_o   = (st_q == ST_CAPT) && (op_q == OP_RD);
    assign cap_idx_o  = idx_q;
    assign cap_data_o = reg_rdata_i;

    assign busy_o = (st_q != ST_IDLE) || done_q;
    assign done_o = done_q;
    assign err_o  = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_WR;
            cnt_q  <= '0;
            idx_q  <= '0;
            req_q  <= '0;
            old_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        req_q <= req_buf_i;
                        op_q  <= op_i;
                        cnt_q <= count_i;
                        idx_q <= '0;
                        if (ok_i) begin
                            st_q <= ST_ISSUE;
                        end else begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (op_q == OP_WR) begin
                        if (last) begin
                            st_q   <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end else begin
                        st_q <= ST_CAPT;
                    end
                end
                ST_CAPT: begin
                    if (op_q == OP_RMW) begin
                        old_q <= reg_rdata_i;
                        st_q  <= ST_MOD;
                    end else if (last) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                        st_q  <= ST_ISSUE;
                    end
                end
                ST_MOD: begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o); // R7
    AST_BAD_REQ_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (accept && !ok_i) |=> (done_o && err_o && !reg_we_o)); // R5
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o); // R6
    AST_RMW_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
        (reg_we_o && op_q == OP_RMW) |-> $stable(reg_addr_o)); // R4

endmodule

// File: rtl/pcr_access_engine.sv
module pcr_access_engine
    import pcr_pkg::*;
#(
    parameter int MAX_ITEMS = 5,
    parameter int REQ_BYTES = 20,
    parameter int RSP_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start_i,
    input  logic [MSG_W-1:0]        msg_type_i,
    input  logic [SUB_W-1:0]        sub_id_i,
    input  logic [SIZE_W-1:0]       size_i,
    input  logic [REQ_BYTES*8-1:0]  req_buf_i,
    output logic [ADDR_W-1:0]       reg_addr_o,
    output logic [DATA_W-1:0]       reg_wdata_o,
    output logic                    reg_we_o,
    input  logic [DATA_W-1:0]       reg_rdata_i,
    output logic [RSP_BYTES*8-1:0]  rsp_buf_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    err_o
);

    localparam int IDX_W = $clog2(MAX_ITEMS + 1);

    logic              dec_ok;
    op_e               dec_op;
    logic [IDX_W-1:0]  dec_cnt;
    logic              clr;
    logic              cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic [DATA_W-1:0] cap_data;

    pcr_req_decode #(
        .MAX_ITEMS (MAX_ITEMS),
        .IDX_W     (IDX_W)
    ) u_dec (
        .msg_i   (msg_type_i),
        .sub_i   (sub_id_i),
        .size_i  (size_i),
        .ok_o    (dec_ok),
        .op_o    (dec_op),
        .count_o (dec_cnt)
    );

    pcr_seq #(
        .MAX_ITEMS (MAX_ITEMS),
        .REQ_BYTES (REQ_BYTES),
        .IDX_W     (IDX_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .ok_i        (dec_ok),
        .op_i        (dec_op),
        .count_i     (dec_cnt),
        .req_buf_i   (req_buf_i),
        .reg_addr_o  (reg_addr_o),
        .reg_wdata_o (reg_wdata_o),
        .reg_we_o    (reg_we_o),
        .reg_rdata_i (reg_rdata_i),
        .clr_o       (clr),
        .cap_en_o    (cap_en),
        .cap_idx_o   (cap_idx),
        .cap_data_o  (cap_data),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    pcr_rsp_store #(
        .RSP_BYTES (RSP_BYTES),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .wr_i   (cap_en),
        .idx_i  (cap_idx),
        .data_i (cap_data),
        .rsp_o  (rsp_buf_o)
    );

endmodule

// File: tb/sim_pcr_access_engine.sv
module sim_pcr_access_engine;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] HI = 8'h12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [7:0]   msg = '0;
    logic [3:0]   sub = '0;
    logic [7:0]   size = '0;
    logic [159:0] rbuf = '0;
    logic [15:0]  addr;
    logic [7:0]   wdata;
    logic         we;
    logic [7:0]   rdata;
    logic [127:0] rsp;
    logic         busy, done, err;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcr_access_engine u0 (
        .clk (clk), .rst (rst), .start_i (start), .msg_type_i (msg),
        .sub_id_i (sub), .size_i (size), .req_buf_i (rbuf),
        .reg_addr_o (addr), .reg_wdata_o (wdata), .reg_we_o (we),
        .reg_rdata_i (rdata), .rsp_buf_o (rsp), .busy_o (busy),
        .done_o (done), .err_o (err)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // register-space model: registered read data, writes on enable
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            wr_cnt <= 0;
            rdata  <= '0;
        end else begin
            if (we) begin
                if (addr[15:8] == HI) mem[addr[7:0]] <= wdata;
                wr_cnt <= wr_cnt + 1;
            end
            rdata <= (addr[15:8] == HI) ? mem[addr[7:0]] : 8'hEE;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [7:0] m, input logic [3:0] s,
                           input logic [7:0] sz, input logic [159:0] b,
                           output logic e);
        int cyc;
        @(negedge clk);
        start = 1'b1; msg = m; sub = s; size = sz; rbuf = b;
        @(negedge clk);
        start = 1'b0;
        chk("R6", "busy after accept", busy, 1);
        cyc = 0;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        chk("R7", "done reached", done, 1);
        chk("R6", "busy in done cycle", busy, 1);
        e = err;
        @(negedge clk);
        chk("R7", "done single cycle", done, 0);
        chk("R7", "err only with done", err, 0);
        chk("R6", "busy low after done", busy, 0);
    endtask

    task automatic t_reset;
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "err", err, 0);
        chk("R1", "we", we, 0);
        chk("R1", "rsp", rsp, 0);
    endtask

    task automatic t_read(input int n, input logic [7:0] lows [5], input string req);
        logic [159:0] b = '0;
        logic [127:0] exp = '0;
        logic e;
        int w0 = wr_cnt;
        for (int i = 0; i < n; i++) begin
            b[16*i +: 8]     = lows[i];
            b[16*i + 8 +: 8] = HI;
            exp[8*i +: 8]    = exp_mem[lows[i]];
        end
        run_req(8'hFF, 4'd1, 8'(2 * n), b, e);
        chk(req, "read err", e, 0);
        chk(req, "read result (R8 zero tail)", rsp, exp);
        chk(req, "read makes no write", wr_cnt - w0, 0);
    endtask

    task automatic t_write(input int n, input logic [7:0] lows [5],
                           input logic [7:0] vals [5], input string req);
        logic [159:0] b = '0;
        logic e;
        int w0 = wr_cnt;
        for (int i = 0; i < n; i++) begin
            b[16*i +: 8]         = lows[i];
            b[16*i + 8 +: 8]     = HI;
            b[8*(2*n + i) +: 8]  = vals[i];
            exp_mem[lows[i]]     = vals[i];
        end
        run_req(8'hFF, 4'd0, 8'(3 * n), b, e);
        chk(req, "write err", e, 0);
        chk("R3", "write count", wr_cnt - w0, n);
        for (int i = 0; i < n; i++) chk(req, "written value", mem[lows[i]], vals[i]);
    endtask

    task automatic t_rmw(input logic [7:0] low, input logic [7:0] v, input logic [7:0] mk);
        logic [159:0] b = '0;
        logic e;
        logic [7:0] expv;
        int w0 = wr_cnt;
        b[7:0] = low; b[15:8] = HI; b[23:16] = v; b[31:24] = mk;
        expv = 8'h00;
        for (int k = 0; k < 8; k++) expv[k] = mk[k] ? v[k] : exp_mem[low][k];
        exp_mem[low] = expv;
        run_req(8'hFF, 4'd2, 8'd4, b, e);
        chk("R4", "rmw err", e, 0);
        chk("R4", "rmw single write", wr_cnt - w0, 1);
        chk("R4", "rmw value", mem[low], expv);
    endtask

    task automatic t_bad(input logic [7:0] m, input logic [3:0] s, input logic [7:0] sz,
                         input string req);
        logic [159:0] b = '0;
        logic e;
        int w0 = wr_cnt;
        for (int i = 0; i < 6; i++) begin
            b[16*i +: 8]     = 8'h30;
            b[16*i + 8 +: 8] = HI;
        end
        b[159:96] = {8{8'h5A}};
        run_req(m, s, sz, b, e);
        chk(req, "rejected request flags error", e, 1);
        chk(req, "rejected request makes no write", wr_cnt - w0, 0);
        chk(req, "rejected target untouched", mem[8'h30], exp_mem[8'h30]);
    endtask

    task automatic t_busy_ignore;
        logic [159:0] b = '0;
        logic [159:0] b2 = '0;
        int w0 = wr_cnt;
        int dones = 0;
        for (int i = 0; i < 5; i++) begin
            b[16*i +: 8]     = 8'(8'h60 + i);
            b[16*i + 8 +: 8] = HI;
            b[8*(10 + i) +: 8] = 8'(8'hC0 + i);
            exp_mem[8'h60 + i] = 8'(8'hC0 + i);
        end
        b2[7:0] = 8'h77; b2[15:8] = HI; b2[23:16] = 8'h99;
        @(negedge clk);
        start = 1'b1; msg = 8'hFF; sub = 4'd0; size = 8'd15; rbuf = b;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        start = 1'b1; sub = 4'd0; size = 8'd3; rbuf = b2;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (done) dones++;
            @(negedge clk);
        end
        chk("R6", "one done only", dones, 1);
        chk("R6", "ignored start made no write", mem[8'h77], exp_mem[8'h77]);
        chk("R6", "write count unaffected", wr_cnt - w0, 5);
        for (int i = 0; i < 5; i++) chk("R9", "five-item write", mem[8'h60 + i], 8'(8'hC0 + i));
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] la [5];
        logic [7:0] va [5];
        for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();

        la = '{8'h05, 8'h10, 8'hFF, 8'h00, 8'h00};
        t_read(3, la, "R2");
        la = '{8'h21, 8'h22, 8'h80, 8'h81, 8'h03};
        t_read(5, la, "R9");
        la = '{8'h44, 8'h00, 8'h00, 8'h00, 8'h00};
        t_read(1, la, "R8");

        la = '{8'h50, 8'h51, 8'h00, 8'h00, 8'h00};
        va = '{8'hA1, 8'hB2, 8'h00, 8'h00, 8'h00};
        t_write(2, la, va, "R3");
        la = '{8'h20, 8'h24, 8'h22, 8'h21, 8'h23};
        va = '{8'h50, 8'h51, 8'h52, 8'h53, 8'h54};
        t_write(5, la, va, "R9");
        la = '{8'h20, 8'h24, 8'h22, 8'h00, 8'h00};
        t_read(3, la, "R2");

        t_rmw(8'h40, 8'h3C, 8'hF0);
        t_rmw(8'h41, 8'hFF, 8'h00);
        t_rmw(8'h42, 8'h5A, 8'hFF);
        la = '{8'h40, 8'h41, 8'h42, 8'h00, 8'h00};
        t_read(3, la, "R4");

        t_bad(8'hFF, 4'd1, 8'd0,  "R5");
        t_bad(8'hFF, 4'd1, 8'd3,  "R5");
        t_bad(8'hFF, 4'd0, 8'd4,  "R5");
        t_bad(8'hFF, 4'd1, 8'd12, "R9");
        t_bad(8'hFF, 4'd0, 8'd18, "R9");
        t_bad(8'hFF, 4'd3, 8'd3,  "R5");
        t_bad(8'hFE, 4'd0, 8'd3,  "R5");
        t_bad(8'hFF, 4'd2, 8'd5,  "R5");

        t_busy_ignore();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule